// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block accepts 16-bit command words from a write-only three-wire serial link: an active-low frame enable, a serial clock and a serial data line. The data line is sampled on each falling edge of the serial clock, and the most significant bit arrives first. Each word that is fully received is moved into the system clock domain. There it appears on a 16-bit output together with a valid strobe that lasts exactly one system clock cycle.

A host can send one word per frame by raising the frame enable after the sixteenth falling edge. It can also keep the frame enable low and send words back to back, with every further group of sixteen falling edges forming another word. If the frame enable rises before a word is complete, the partial word is thrown away. The block does not decode what a word means.

The serial side works from the serial clock alone. A completed word is first latched into a holding register, and a toggle flag is flipped. That flag passes through a synchronizer into the system clock domain, which then copies the holding register.

Top module: `serial_word_rx`

## Requirements
- R1: Each word is 16 bits and is assembled most significant bit first: the first bit sampled in a word becomes `word_out[15]` and the sixteenth becomes `word_out[0]`.
- R2: The data line is sampled only on falling edges of the serial clock. Changes of the data line between a falling edge and the next rising edge do not alter the received word.
- R3: Falling edges of the serial clock that occur while `fsync_n` is high have no effect on the bit count or on the word being assembled, and produce no strobe.
- R4: A frame of exactly sixteen falling edges, ended by raising `fsync_n`, delivers exactly one word.
- R5: While `fsync_n` stays low, the bit counter wraps after each sixteenth falling edge, and each further group of sixteen edges delivers another word, in arrival order.
- R6: If `fsync_n` rises after fewer than sixteen bits of the current word, that partial word is discarded without a strobe, and the next frame starts again at bit 15.
- R7: `word_valid` is high for exactly one system clock cycle per delivered word, and `word_out` changes only in a cycle where `word_valid` is high.
- R8: While `rst_n` is low and after it is released, `word_valid` is 0 and `word_out` is 0 until the first word is delivered.
- R9: The serial clock may idle low between frames, provided it is high when `fsync_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fsync_n | input | 1 | Active-low frame enable; high aborts and clears the frame |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| word_out | output | 16 | Last delivered word, system clock domain |
| word_valid | output | 1 | One-cycle strobe marking a new `word_out` |

## Verification
The tests send single-word frames with walking and extreme bit patterns; these show whether bit order and bit position are right. Streams of several words in one frame test the counter wrap and word ordering. Frames aborted after 7 and 15 bits test the discard of partial words and the restart of the bit count. Extra serial clock edges while the frame is inactive, an idle-low clock, and a data line that flips right after each falling edge each separate correct edge and frame qualification from sampling too much or at the wrong time.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;

    localparam int unsigned DEF_WORD_BITS   = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Width of a counter that indexes every bit of a word
    function automatic int unsigned bit_cnt_width(input int unsigned bits);
        return (bits <= 2) ? 1 : $clog2(bits);
    endfunction

endpackage

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int unsigned WORD_BITS = serial_word_rx_pkg::DEF_WORD_BITS
) (
    input  logic                 rst_n,
    input  logic                 fsync_n,
    input  logic                 sclk,
    input  logic                 sdata,
    output logic [WORD_BITS-1:0] hold_word,
    output logic                 hold_tog
);

    localparam int unsigned CNT_W = serial_word_rx_pkg::bit_cnt_width(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [WORD_BITS-2:0] shf;
    } frame_t;

    typedef struct packed {
        logic [WORD_BITS-1:0] word;
        logic                 tog;
    } hold_t;

    frame_t frm_d, frm_q;
    hold_t  hld_d, hld_q;
    logic [WORD_BITS-1:0] assembled;

    always_comb begin
        frm_d     = frm_q;
        hld_d     = hld_q;
        assembled = {frm_q.shf, sdata};
        frm_d.shf = assembled[WORD_BITS-2:0];
        if (frm_q.cnt == LAST_BIT) begin
            frm_d.cnt  = '0;
            hld_d.word = assembled;
            hld_d.tog  = ~hld_q.tog;
        end else begin
            frm_d.cnt = frm_q.cnt + 1'b1;
        end
    end

    // Frame state is held clear whenever the frame enable is high
    always_ff @(negedge sclk or posedge fsync_n or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else if (fsync_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    // Completed-word register survives frame ends
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            hld_q <= '0;
        end else begin
            hld_q <= hld_d;
        end
    end

    assign hold_word = hld_q.word;
    assign hold_tog  = hld_q.tog;

    // R5
    cnt_wrap_chk: assert property (@(negedge sclk) disable iff (!rst_n || fsync_n)
        (frm_q.cnt == LAST_BIT) |=> (frm_q.cnt == '0));

    // R6
    tog_on_full_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        !$stable(hld_q.tog) |-> ($past(frm_q.cnt) == LAST_BIT));

    // R7
    hold_quiet_chk: assert property (@(negedge sclk) disable iff (!rst_n)
        $stable(hld_q.tog) |-> $stable(hld_q.word));

endmodule

// File: rtl/srx_toggle_sync.sv
module srx_toggle_sync #(
    parameter int unsigned STAGES = serial_word_rx_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[N-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q[N-1];

endmodule

// File: rtl/srx_capture.sv
module srx_capture #(
    parameter int unsigned WORD_BITS = serial_word_rx_pkg::DEF_WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tog_sync,
    input  logic [WORD_BITS-1:0] hold_word,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid
);

    typedef struct packed {
        logic                 seen;
        logic                 valid;
        logic [WORD_BITS-1:0] word;
    } cap_t;

    cap_t cap_d, cap_q;
    logic new_word;

    always_comb begin
        cap_d       = cap_q;
        new_word    = tog_sync ^ cap_q.seen;
        cap_d.seen  = tog_sync;
        cap_d.valid = new_word;
        if (new_word) begin
            cap_d.word = hold_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word_out   = cap_q.word;
    assign word_valid = cap_q.valid;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> word_valid);

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!word_valid && word_out == '0));

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
    parameter int unsigned WORD_BITS   = serial_word_rx_pkg::DEF_WORD_BITS,
    parameter int unsigned SYNC_STAGES = serial_word_rx_pkg::DEF_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync_n,
    input  logic                 sclk,
    input  logic                 sdata,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid
);

    logic [WORD_BITS-1:0] hold_word;
    logic                 hold_tog;
    logic                 tog_sync;

    srx_shifter #(.WORD_BITS(WORD_BITS)) u_shifter (
        .rst_n     (rst_n),
        .fsync_n   (fsync_n),
        .sclk      (sclk),
        .sdata     (sdata),
        .hold_word (hold_word),
        .hold_tog  (hold_tog)
    );

    srx_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hold_tog),
        .dout  (tog_sync)
    );

    srx_capture #(.WORD_BITS(WORD_BITS)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .tog_sync   (tog_sync),
        .hold_word  (hold_word),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

endmodule

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam time SCLK_HALF  = 30ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdata = 1'b0;
    logic [15:0] word_out;
    logic        word_valid;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_word_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync_n    (fsync_n),
        .sclk       (sclk),
        .sdata      (sdata),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    // Shift nbits of w, MSB first, inside the current frame.
    // Data is flipped just after each falling edge (R2).
    task automatic shift_bits(input logic [15:0] w, input int nbits, input string tag);
        for (int i = 0; i < nbits; i++) begin
            sdata = w[15-i];
            #(SCLK_HALF);
            sclk = 1'b0;
            if (i == 15) begin
                exp_q.push_back(w);
                tag_q.push_back(tag);
            end
            #1ns;
            sdata = ~w[15-i];
            #(SCLK_HALF - 1ns);
            sclk = 1'b1;
        end
    endtask

    task automatic open_frame();
        sclk = 1'b1;
        #(SCLK_HALF);
        fsync_n = 1'b0;
        #(SCLK_HALF);
    endtask

    task automatic close_frame();
        #(SCLK_HALF);
        fsync_n = 1'b1;
        #(SCLK_HALF * 4);
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        open_frame();
        shift_bits(w, 16, tag);
        close_frame();
    endtask

    // Scoreboard monitor
    logic [15:0] last_word = '0;
    bit          prev_valid = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (word_valid) begin
                checks++;
                if (prev_valid) begin
                    fails++;
                    $display("FAIL R7 strobe longer than one cycle: actual valid=1 expected valid=0");
                end else if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected word: actual %h expected none", word_out);
                end else begin
                    logic [15:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (word_out !== e) begin
                        fails++;
                        $display("FAIL %s word: actual %h expected %h", t, word_out, e);
                    end
                end
                last_word = word_out;
            end else if (word_out !== last_word) begin
                checks++;
                fails++;
                $display("FAIL R7 word changed without strobe: actual %h expected %h", word_out, last_word);
                last_word = word_out;
            end
            prev_valid = word_valid;
        end
    end

    initial begin
        // R8 reset state
        #(CLK_PERIOD * 3 + CLK_PERIOD/2);
        checks++;
        if (word_valid !== 1'b0 || word_out !== 16'h0) begin
            fails++;
            $display("FAIL R8 in reset: actual %b/%h expected 0/0000", word_valid, word_out);
        end
        rst_n = 1'b1;
        #(CLK_PERIOD * 4);
        checks++;
        if (word_valid !== 1'b0 || word_out !== 16'h0) begin
            fails++;
            $display("FAIL R8 after reset: actual %b/%h expected 0/0000", word_valid, word_out);
        end
        mon_en = 1'b1;

        // R4 / R1 single-word frames
        send_word(16'hA55A, "R4");
        send_word(16'h8000, "R1");
        send_word(16'h0001, "R1");
        send_word(16'hFFFF, "R1");
        send_word(16'h0000, "R4");

        // R5 streaming within one frame
        open_frame();
        shift_bits(16'h1234, 16, "R5");
        shift_bits(16'hABCD, 16, "R5");
        shift_bits(16'h0F0F, 16, "R5");
        close_frame();

        // R6 aborted partial words, then a clean word
        open_frame();
        shift_bits(16'hFFFF, 7, "R6");
        close_frame();
        send_word(16'hC3C3, "R6");
        open_frame();
        shift_bits(16'h7777, 15, "R6");
        close_frame();
        send_word(16'h3C3C, "R6");

        // R3 clock edges while frame inactive
        for (int i = 0; i < 5; i++) begin
            sdata = i[0];
            #(SCLK_HALF);
            sclk = 1'b0;
            #(SCLK_HALF);
            sclk = 1'b1;
        end
        send_word(16'h5A5A, "R3");

        // R9 clock idles low between frames
        sclk = 1'b0;
        #(SCLK_HALF * 6);
        send_word(16'h6996, "R9");
        sclk = 1'b0;
        #(SCLK_HALF * 6);
        send_word(16'h2468, "R2");

        #(CLK_PERIOD * 20);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 words missing: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule